// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Sequencer

This block fetches one byte from a serial EEPROM on a two-wire bus. The EEPROM uses a 16-bit memory address. The host pulses `start` with an address. The sequencer then runs the whole transaction on its own and reports the result with a one-cycle `done` pulse, an error flag and the byte it read.

The transaction runs in this order:

1. A start condition.
2. A dummy write that sends the device write selector (0xA0), then the high address byte, then the low address byte.
3. A repeated start.
4. The device read selector (0xA1).
5. Eight data bits clocked in from the device.
6. A stop condition.

The device must acknowledge each byte the sequencer writes. If an acknowledge is missing, the sequencer skips straight to the stop condition and flags an error.

The bus clock comes from the system clock through a divider. Each bus-clock period has four quarters of `QTR` system cycles each:

| Quarter | Bus clock | Data line |
|---------|-----------|-----------|
| q0 | low | keeps its previous level |
| q1 | low | may take a new value |
| q2 | high | stable |
| q3 | high | stable, except for the start and stop edges |

The data line is open drain. The block drives it only through an enable and a value. It reads the wired level back on `sda_i`.

Top module: `ee_rand_reader`

## Requirements
- R1: Out of reset, and whenever idle, `scl_o` is 1 and `sda_oe` is 0. After reset, `done`, `err` and `rdata` are 0.
- R2: Each start condition is one slot with these quarters:
  - q1: clock low, data driven 1.
  - q2: clock high, data driven 1.
  - q3: clock high, data driven 0.

  A repeated start is issued after the low-address acknowledge.
- R3: Written bytes go out in this order: 0xA0, addr[15:8], addr[7:0], then 0xA1 after the repeated start. Each byte is sent most significant bit first, one bit per slot, driven from q1 to q3. The address is taken at the accepted `start`.
- R4: The data level never changes while the clock is high, except at the q3 edge of a start or stop slot.
- R5: After each written byte, a ninth slot releases the data line and samples `sda_i` at the end of q3. A sampled 1 makes the next slot a stop, and `err` is reported as 1.
- R6: The read byte is eight released slots. Each samples `sda_i` at the end of its q3, and the byte is assembled most significant bit first. No acknowledge slot follows; the stop comes next.
- R7: Every transaction ends with a stop slot, including after an error. The stop slot's quarters are:
  - q1: clock low, data driven 0.
  - q2: clock high, data driven 0.
  - q3: clock high, data driven 1.

  After the stop, the line returns to idle.
- R8: `done` is high for exactly one cycle, in the first idle cycle after the stop. In that same cycle, `err` and `rdata` are valid, and `rdata` is 0 on error.
- R9: An accepted `start` clears `err` and `rdata`. Both then hold until the next accepted `start`. A `start` that arrives while a transaction is running is ignored.
- R10: Every quarter lasts `QTR` system cycles. `scl_o` is high exactly in q2 and q3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read; honoured only when idle |
| addr | input | 16 | EEPROM byte address, taken at start |
| sda_i | input | 1 | Wired level of the data line |
| scl_o | output | 1 | Bus clock |
| sda_oe | output | 1 | Data line drive enable |
| sda_o | output | 1 | Data line drive value |
| rdata | output | 8 | Byte read; 0 after an error |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Missing acknowledge in the last transaction |

## Verification
A wrong slot kind, bit index or byte index shows up on `sda_oe`/`sda_o` in the q1 of the slot concerned. That is at most one quarter (`QTR` cycles) after the slot starts. A bad divider or quarter count shows on `scl_o` within one quarter. The bench therefore compares all three line signals against a slot-level model on every cycle.

A wrongly taken acknowledge branch diverges at the very next slot. Either an extra stop appears or an expected one is missing. The completion pulse then lands at the wrong cycle, which exposes the error.

// File: rtl/ee_rand_reader.sv
module ee_rand_reader #(
  parameter int QTR = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] addr,
  input  logic        sda_i,
  output logic        scl_o,
  output logic        sda_oe,
  output logic        sda_o,
  output logic [7:0]  rdata,
  output logic        done,
  output logic        err
);
  localparam int DW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QTR - 1);

  typedef enum logic [2:0] {K_IDLE, K_START, K_WBIT, K_ACK, K_RBIT, K_STOP} kind_t;

  kind_t       kind;
  logic [DW-1:0] div;
  logic [1:0]  q;
  logic [2:0]  bitn;
  logic [1:0]  byten;
  logic [15:0] addr_r;
  logic [7:0]  shreg;
  logic        nack;
  logic        hold_oe, hold_o;
  logic        want_oe, want_o;
  logic [7:0]  cur_byte;
  logic        busy;

  wire tick     = (div == DIV_LAST);
  wire slot_end = tick && (q == 2'd3);

  always_comb begin
    case (byten)
      2'd0:    cur_byte = 8'hA0;
      2'd1:    cur_byte = addr_r[15:8];
      2'd2:    cur_byte = addr_r[7:0];
      default: cur_byte = 8'hA1;
    endcase
  end

  always_comb begin
    want_oe = 1'b0;
    want_o  = 1'b1;
    case (kind)
      K_START: begin want_oe = 1'b1; want_o = (q != 2'd3);     end
      K_WBIT:  begin want_oe = 1'b1; want_o = cur_byte[bitn];  end
      K_STOP:  begin want_oe = 1'b1; want_o = (q == 2'd3);     end
      default: ;
    endcase
  end

  assign busy   = (kind != K_IDLE);
  assign scl_o  = busy ? q[1] : 1'b1;
  assign sda_oe = busy ? ((q == 2'd0) ? hold_oe : want_oe) : 1'b0;
  assign sda_o  = busy ? ((q == 2'd0) ? hold_o  : want_o)  : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind    <= K_IDLE;
      div     <= '0;
      q       <= 2'd0;
      bitn    <= 3'd0;
      byten   <= 2'd0;
      addr_r  <= 16'h0;
      shreg   <= 8'h0;
      nack    <= 1'b0;
      hold_oe <= 1'b0;
      hold_o  <= 1'b1;
      rdata   <= 8'h0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          kind    <= K_START;
          div     <= '0;
          q       <= 2'd0;
          byten   <= 2'd0;
          addr_r  <= addr;
          nack    <= 1'b0;
          hold_oe <= 1'b0;
          hold_o  <= 1'b1;
          rdata   <= 8'h0;
          err     <= 1'b0;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) q <= q + 2'd1;
        if (slot_end) begin
          hold_oe <= want_oe;
          hold_o  <= want_o;
          case (kind)
            K_START: begin
              kind <= K_WBIT;
              bitn <= 3'd7;
            end
            K_WBIT: begin
              if (bitn == 3'd0) kind <= K_ACK;
              else              bitn <= bitn - 3'd1;
            end
            K_ACK: begin
              if (sda_i) begin
                nack <= 1'b1;
                kind <= K_STOP;
              end else if (byten == 2'd2) begin
                byten <= 2'd3;
                kind  <= K_START;
              end else if (byten == 2'd3) begin
                kind <= K_RBIT;
                bitn <= 3'd7;
              end else begin
                byten <= byten + 2'd1;
                kind  <= K_WBIT;
                bitn  <= 3'd7;
              end
            end
            K_RBIT: begin
              shreg <= {shreg[6:0], sda_i};
              if (bitn == 3'd0) kind <= K_STOP;
              else              bitn <= bitn - 3'd1;
            end
            K_STOP: begin
              kind  <= K_IDLE;
              done  <= 1'b1;
              err   <= nack;
              rdata <= nack ? 8'h0 : shreg;
            end
            default: kind <= K_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ee_rand_reader_chk.sv
module ee_rand_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       scl_o,
  input logic       sda_oe,
  input logic       sda_o,
  input logic       done,
  input logic       err,
  input logic [7:0] rdata,
  input logic       busy
);
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  a_r4_no_data_move_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) |-> ($stable(sda_oe) && $stable(sda_o)));

  a_r4_no_data_move_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> ($stable(sda_oe) && $stable(sda_o)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r5_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rdata) && $stable(err)));
endmodule

bind ee_rand_reader ee_rand_reader_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .scl_o  (scl_o),
  .sda_oe (sda_oe),
  .sda_o  (sda_o),
  .done   (done),
  .err    (err),
  .rdata  (rdata),
  .busy   (busy)
);

// File: tb/ee_rand_reader_tb.sv
module ee_rand_reader_tb;
  localparam int Q = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = 16'h0;
  logic        slave = 1'b1;
  logic        sda_i;
  logic        scl_o, sda_oe, sda_o, done, err;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int kd [0:63];
  int vl [0:63];
  int ns;

  always #10 clk = ~clk;

  assign sda_i = slave & ~(sda_oe & ~sda_o);

  ee_rand_reader #(.QTR(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .sda_i(sda_i),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_o(sda_o),
    .rdata(rdata), .done(done), .err(err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(input int k, input int v);
    kd[ns] = k;
    vl[ns] = v;
    ns++;
  endtask

  // kinds: 0 start, 1 write bit, 2 ack, 3 read bit, 4 stop
  task automatic build(input logic [15:0] a, input logic [7:0] d, input int nk);
    logic [7:0] by;
    ns = 0;
    push(0, 0);
    for (int b = 0; b < 4; b++) begin
      if (b == 3) push(0, 0);
      case (b)
        0: by = 8'hA0;
        1: by = a[15:8];
        2: by = a[7:0];
        default: by = 8'hA1;
      endcase
      for (int i = 7; i >= 0; i--) push(1, int'(by[i]));
      push(2, (b == nk) ? 1 : 0);
      if (b == nk) begin
        push(4, 0);
        return;
      end
    end
    for (int i = 7; i >= 0; i--) push(3, int'(d[i]));
    push(4, 0);
  endtask

  function automatic logic [1:0] drv(input int k, input int qq, input int v);
    case (k)
      0: return {1'b1, (qq != 3)};
      1: return {1'b1, v[0]};
      4: return {1'b1, (qq == 3)};
      default: return 2'b01;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_txn(input logic [15:0] a, input logic [7:0] d, input int nk, input bit interfere);
    int total;
    logic prev_scl, prev_sda;
    build(a, d, nk);
    total = ns * 4 * Q;
    @(negedge clk);
    start = 1'b1;
    addr  = a;
    @(negedge clk);
    start = 1'b0;
    addr  = ~a;
    prev_scl = 1'b0;
    prev_sda = 1'b1;
    for (int c = 0; c < total; c++) begin
      int s;
      int qq;
      logic [1:0] e;
      logic cur_sda;
      s  = c / (4 * Q);
      qq = (c / Q) % 4;
      if (interfere && c == total / 2 + 1) start = 1'b0;
      slave = (kd[s] == 2 || kd[s] == 3) ? vl[s][0] : 1'b1;
      if (qq == 0) e = (s == 0) ? 2'b01 : drv(kd[s-1], 3, vl[s-1]);
      else         e = drv(kd[s], qq, vl[s]);
      check("R10", "scl", int'(scl_o), (qq >= 2) ? 1 : 0);
      check(tag_of(kd[s]), "oe", int'(sda_oe), int'(e[1]));
      if (e[1]) check(tag_of(kd[s]), "o", int'(sda_o), int'(e[0]));
      check("R8", "done busy", int'(done), 0);
      check("R9", "err busy", int'(err), 0);
      check("R9", "rdata busy", int'(rdata), 0);
      cur_sda = sda_oe ? sda_o : 1'b1;
      if (scl_o && prev_scl && (cur_sda != prev_sda) && kd[s] != 0 && kd[s] != 4)
        check("R4", "sda moved with scl high", 1, 0);
      prev_scl = scl_o;
      prev_sda = cur_sda;
      if (interfere && c == total / 2) start = 1'b1;
      @(negedge clk);
    end
    slave = 1'b1;
    check("R8", "done pulse", int'(done), 1);
    check("R5", "err", int'(err), (nk < 4) ? 1 : 0);
    check("R6", "rdata", int'(rdata), (nk < 4) ? 0 : int'(d));
    check("R7", "scl idle", int'(scl_o), 1);
    check("R7", "oe idle", int'(sda_oe), 0);
    @(negedge clk);
    check("R8", "done drops", int'(done), 0);
    repeat (3) @(negedge clk);
    check("R9", "rdata hold", int'(rdata), (nk < 4) ? 0 : int'(d));
    check("R9", "err hold", int'(err), (nk < 4) ? 1 : 0);
    check("R1", "idle scl", int'(scl_o), 1);
    check("R1", "idle oe", int'(sda_oe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset scl", int'(scl_o), 1);
    check("R1", "reset oe", int'(sda_oe), 0);
    check("R1", "reset done", int'(done), 0);
    check("R1", "reset err", int'(err), 0);
    check("R1", "reset rdata", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(16'h1234, 8'h5A, 4, 1'b0);
    run_txn(16'hFFFF, 8'h00, 4, 1'b0);
    run_txn(16'h0000, 8'hFF, 4, 1'b1);
    run_txn(16'h0F0F, 8'h3C, 0, 1'b0);
    run_txn(16'hBEEF, 8'h77, 1, 1'b0);
    run_txn(16'h8001, 8'h11, 2, 1'b1);
    run_txn(16'h4321, 8'h99, 3, 1'b0);
    run_txn(16'hA55A, 8'h81, 4, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule